// File: doc/BRIEF.md
# Dual-Channel Mode Control and Bypass Relay

This block sits between the serial ports of a two-channel voice transcoder and its compression core. On every internal frame pulse it captures one PCM octet and one compressed word per channel. It samples each channel's 2-bit mode and moves every sample through a fixed two-frame pipeline.

Each channel has its own mode, which decides what is produced in the processing frame:
- **Coding modes (32 kbit/s or 24 kbit/s):** the sample goes through a stand-in for the compression arithmetic.
- **Bypass:** the compressed word and the upper half of the PCM octet are relayed unchanged between the two sides.
- **Algorithm reset:** the outputs are held at zero.

The block also watches for a reset held on both channels for four frames, which drives a reset request toward the core. It flags a reset requested on only one channel. For each channel it publishes a registered rate selection (word length 4 or 3, or 0 when not coding).

The stand-in core is deliberately simple so that results can be predicted exactly:
- It encodes an octet `p` as `p[7:4] ^ p[3:0]`.
- It decodes a word `w` as `{w, ~w}`.

Top module: `chan_mode_relay`

## Requirements
- R1: On each frame pulse each channel's 2-bit mode is sampled. The mode codes are 00 algorithm reset, 01 bypass, 10 24 kbit/s and 11 32 kbit/s. From the cycle after the pulse, rate_sel shows 4 for code 11, 3 for code 10 and 0 otherwise, and holds for the whole frame. Mode changes between pulses have no effect.
- R2: The two channels use their own mode inputs and data. A mode on one channel never changes the other channel's results.
- R3: In 32 kbit/s mode the compressed output is `pcm[7:4] ^ pcm[3:0]` and the PCM output is `{adp, ~adp}`.
- R4: In 24 kbit/s mode the 3-bit word sits in bits 3:1 of the nibble and bit 0 is 0. The compressed output is `(pcm[7:4] ^ pcm[3:0]) & 4'b1110`. The PCM output decodes the word with its bit 0 cleared: `{w, ~w}` where `w = adp & 4'b1110`.
- R5: In bypass mode the PCM output is `{adp, 4'b0000}` (word in bits 7:4, bits 3:0 zero). The compressed output is `pcm[7:4]`.
- R6: A sample captured at pulse k appears at the outputs from the cycle after pulse k+2. Data outputs change only in the cycle after a pulse.
- R7: A sample captured at pulse k is converted under the mode sampled at pulse k+1, so the rate can change from frame to frame.
- R8: reset_req rises at the fourth consecutive pulse where both mode inputs are 00. It stays high while that continues, with its frame counter saturating, and falls at the first pulse where any mode bit is 1.
- R9: A channel in algorithm-reset mode outputs zero on both sides. part_rst_err is 1 for each frame whose pulse saw exactly one channel at 00, and 0 otherwise.
- R10: While rst is high, and after it until the next pulse, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_pulse | input | 1 | One-cycle internal frame pulse |
| mode_in | input | NCH x 2 | Per-channel mode code |
| pcm_in | input | NCH x PCM_W | Per-channel PCM octet captured at the pulse |
| adp_in | input | NCH x ADP_W | Per-channel compressed word captured at the pulse |
| pcm_out | output | NCH x PCM_W | Per-channel PCM result |
| adp_out | output | NCH x ADP_W | Per-channel compressed result |
| rate_sel | output | NCH x 3 | Per-channel word length: 4, 3 or 0 |
| reset_req | output | 1 | Algorithm reset request to the core |
| part_rst_err | output | 1 | Reset requested on only some channels |

## Verification
The three kinds of result have different timing:
- Data results are due one cycle after the edge of the second pulse following capture, and use the mode of the first of those two pulses.
- rate_sel, reset_req and part_rst_err are due one cycle after the very pulse that sampled the modes.

The bench drives each pulse on a falling edge and checks every output at the next falling edge, where all of these results are settled. It then scrambles the inputs mid-frame and checks again at the last falling edge before the next pulse. This confirms that nothing moved between pulses.

// File: rtl/chan_mode_relay_pkg.sv
package chan_mode_relay_pkg;

    localparam int PCM_W  = 8;
    localparam int ADP_W  = 4;
    localparam int RATE_W = 3;

    typedef enum logic [1:0] {
        MODE_RST = 2'b00,
        MODE_BYP = 2'b01,
        MODE_R24 = 2'b10,
        MODE_R32 = 2'b11
    } mode_e;

    typedef struct packed {
        logic [PCM_W-1:0] pcm;
        logic [ADP_W-1:0] adp;
    } chan_word_t;

    localparam logic [ADP_W-1:0] NARROW_MASK = {{(ADP_W-1){1'b1}}, 1'b0};

    // Stand-in for the compression arithmetic: fold the octet halves.
    function automatic logic [ADP_W-1:0] stub_encode(input logic [PCM_W-1:0] oct);
        return oct[PCM_W-1 -: ADP_W] ^ oct[ADP_W-1:0];
    endfunction

    // Stand-in for the expansion arithmetic: word and its complement.
    function automatic logic [PCM_W-1:0] stub_decode(input logic [ADP_W-1:0] w);
        return {w, ~w};
    endfunction

    function automatic logic [RATE_W-1:0] rate_of(input mode_e m);
        logic [RATE_W-1:0] r;
        case (m)
            MODE_R32: r = RATE_W'(ADP_W);
            MODE_R24: r = RATE_W'(ADP_W - 1);
            default:  r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mcr_core_stub.sv
module mcr_core_stub
    import chan_mode_relay_pkg::*;
(
    input  mode_e      mode,
    input  chan_word_t work,
    output chan_word_t res
);
    logic [ADP_W-1:0] enc_full;
    logic [ADP_W-1:0] adp_narrow;
    logic [PCM_W-1:0] byp_pcm;

    assign enc_full   = stub_encode(work.pcm);
    assign adp_narrow = work.adp & NARROW_MASK;
    assign byp_pcm    = {work.adp, {(PCM_W-ADP_W){1'b0}}};

    always_comb begin
        res = '0;
        case (mode)
            MODE_R32: begin
                res.adp = enc_full;
                res.pcm = stub_decode(work.adp);
            end
            MODE_R24: begin
                res.adp = enc_full & NARROW_MASK;
                res.pcm = stub_decode(adp_narrow);
            end
            MODE_BYP: begin
                res.adp = work.pcm[PCM_W-1 -: ADP_W];
                res.pcm = byp_pcm;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/mcr_chan_pipe.sv
module mcr_chan_pipe
    import chan_mode_relay_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_pulse,
    input  logic [1:0]        mode_in,
    input  logic [PCM_W-1:0]  pcm_in,
    input  logic [ADP_W-1:0]  adp_in,
    output logic [PCM_W-1:0]  pcm_out,
    output logic [ADP_W-1:0]  adp_out,
    output logic [RATE_W-1:0] rate_sel
);
    chan_word_t        load_q;
    chan_word_t        work_q;
    chan_word_t        out_q;
    chan_word_t        res;
    mode_e             mode_q;
    mode_e             mode_now;
    logic [RATE_W-1:0] rate_q;

    assign mode_now = mode_e'(mode_in);

    mcr_core_stub u_core (
        .mode (mode_q),
        .work (work_q),
        .res  (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            work_q <= '0;
            out_q  <= '0;
            mode_q <= MODE_RST;
            rate_q <= '0;
        end else if (frm_pulse) begin
            load_q.pcm <= pcm_in;
            load_q.adp <= adp_in;
            work_q     <= load_q;
            out_q      <= res;
            mode_q     <= mode_now;
            rate_q     <= rate_of(mode_now);
        end
    end

    assign pcm_out  = out_q.pcm;
    assign adp_out  = out_q.adp;
    assign rate_sel = rate_q;
endmodule

// File: rtl/mcr_reset_detect.sv
module mcr_reset_detect #(
    parameter int NCH        = 2,
    parameter int RST_FRAMES = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           frm_pulse,
    input  logic [NCH-1:0] chan_zero,
    output logic           reset_req,
    output logic           part_rst_err
);
    localparam int CNT_W = $clog2(RST_FRAMES) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(RST_FRAMES);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             all_zero;
    logic             some_zero;

    assign all_zero  = &chan_zero;
    assign some_zero = |chan_zero;
    assign cnt_nx    = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q        <= '0;
            reset_req    <= 1'b0;
            part_rst_err <= 1'b0;
        end else if (frm_pulse) begin
            part_rst_err <= some_zero & ~all_zero;
            if (all_zero) begin
                cnt_q     <= cnt_nx;
                reset_req <= (cnt_nx >= CNT_HIT);
            end else begin
                cnt_q     <= '0;
                reset_req <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/chan_mode_relay.sv
module chan_mode_relay
    import chan_mode_relay_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int RST_FRAMES = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frm_pulse,
    input  logic [NCH-1:0][1:0]           mode_in,
    input  logic [NCH-1:0][PCM_W-1:0]     pcm_in,
    input  logic [NCH-1:0][ADP_W-1:0]     adp_in,
    output logic [NCH-1:0][PCM_W-1:0]     pcm_out,
    output logic [NCH-1:0][ADP_W-1:0]     adp_out,
    output logic [NCH-1:0][RATE_W-1:0]    rate_sel,
    output logic                          reset_req,
    output logic                          part_rst_err
);
    logic [NCH-1:0] chan_zero;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        assign chan_zero[ch] = (mode_in[ch] == MODE_RST);

        mcr_chan_pipe u_pipe (
            .clk       (clk),
            .rst       (rst),
            .frm_pulse (frm_pulse),
            .mode_in   (mode_in[ch]),
            .pcm_in    (pcm_in[ch]),
            .adp_in    (adp_in[ch]),
            .pcm_out   (pcm_out[ch]),
            .adp_out   (adp_out[ch]),
            .rate_sel  (rate_sel[ch])
        );
    end

    mcr_reset_detect #(
        .NCH        (NCH),
        .RST_FRAMES (RST_FRAMES)
    ) u_rdet (
        .clk          (clk),
        .rst          (rst),
        .frm_pulse    (frm_pulse),
        .chan_zero    (chan_zero),
        .reset_req    (reset_req),
        .part_rst_err (part_rst_err)
    );
endmodule

// File: rtl/chan_mode_relay_chk.sv
module chan_mode_relay_chk
    import chan_mode_relay_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       frm_pulse,
    input logic [NCH-1:0][1:0]        mode_in,
    input logic [NCH-1:0][PCM_W-1:0]  pcm_out,
    input logic [NCH-1:0][ADP_W-1:0]  adp_out,
    input logic [NCH-1:0][RATE_W-1:0] rate_sel,
    input logic                       reset_req,
    input logic                       part_rst_err
);
    AST_DATA_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frm_pulse |=> ($stable(pcm_out) && $stable(adp_out))); // R6

    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frm_pulse |=> $stable(rate_sel)); // R1

    for (genvar ch = 0; ch < NCH; ch++) begin : g_rate
        AST_RATE_CODE: assert property (@(posedge clk) disable iff (rst)
            (rate_sel[ch] == 3'd0 || rate_sel[ch] == 3'd3 || rate_sel[ch] == 3'd4)); // R1
    end

    AST_RST_REQ_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_req) |-> ($past(frm_pulse) && $past(mode_in) == '0)); // R8

    AST_RST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (frm_pulse && mode_in != '0) |=> !reset_req); // R8

    AST_PART_ERR_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(part_rst_err) |-> $past(frm_pulse)); // R9

    AST_PART_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(part_rst_err && reset_req)); // R9
endmodule

bind chan_mode_relay chan_mode_relay_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .frm_pulse    (frm_pulse),
    .mode_in      (mode_in),
    .pcm_out      (pcm_out),
    .adp_out      (adp_out),
    .rate_sel     (rate_sel),
    .reset_req    (reset_req),
    .part_rst_err (part_rst_err)
);

// File: tb/chan_mode_relay_bench.sv
module chan_mode_relay_bench;
    localparam int NCH = 2;
    localparam int FRAME_LEN = 8;
    localparam int HMAX = 512;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                 rst;
    logic                 frm_pulse;
    logic [NCH-1:0][1:0]  mode_in;
    logic [NCH-1:0][7:0]  pcm_in;
    logic [NCH-1:0][3:0]  adp_in;
    logic [NCH-1:0][7:0]  pcm_out;
    logic [NCH-1:0][3:0]  adp_out;
    logic [NCH-1:0][2:0]  rate_sel;
    logic                 reset_req;
    logic                 part_rst_err;

    chan_mode_relay u_chan_mode_relay (
        .clk(clk), .rst(rst), .frm_pulse(frm_pulse), .mode_in(mode_in),
        .pcm_in(pcm_in), .adp_in(adp_in), .pcm_out(pcm_out), .adp_out(adp_out),
        .rate_sel(rate_sel), .reset_req(reset_req), .part_rst_err(part_rst_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    int fidx = 0;
    int zrun = 0;
    logic [1:0] h_mode [HMAX][NCH];
    logic [7:0] h_pcm  [HMAX][NCH];
    logic [3:0] h_adp  [HMAX][NCH];

    function automatic logic [3:0] exp_adp(logic [1:0] m, logic [7:0] p);
        case (m)
            2'b01:   return p[7:4];
            2'b10:   return (p[7:4] ^ p[3:0]) & 4'hE;
            2'b11:   return p[7:4] ^ p[3:0];
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [7:0] exp_pcm(logic [1:0] m, logic [3:0] a);
        logic [3:0] w;
        w = a & 4'hE;
        case (m)
            2'b01:   return {a, 4'h0};
            2'b10:   return {w, ~w};
            2'b11:   return {a, ~a};
            default: return 8'h00;
        endcase
    endfunction

    function automatic int exp_rate(logic [1:0] m);
        return (m == 2'b11) ? 4 : (m == 2'b10) ? 3 : 0;
    endfunction

    function automatic string mtag(logic [1:0] m);
        case (m)
            2'b01:   return "R5";
            2'b10:   return "R4";
            2'b11:   return "R3";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [1:0] hm(int f, int ch);
        return (f < 0) ? 2'b00 : h_mode[f][ch];
    endfunction
    function automatic logic [7:0] hp(int f, int ch);
        return (f < 0) ? 8'h00 : h_pcm[f][ch];
    endfunction
    function automatic logic [3:0] ha(int f, int ch);
        return (f < 0) ? 4'h0 : h_adp[f][ch];
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s frame %0d actual=%0h expected=%0h", tag, fidx, act, exp);
        end
    endtask

    task automatic do_frame(string ph, logic [1:0] m1, logic [1:0] m2,
                            logic [7:0] p1, logic [7:0] p2, logic [3:0] a1, logic [3:0] a2);
        logic [NCH-1:0][7:0] s_pcm;
        logic [NCH-1:0][3:0] s_adp;
        logic [NCH-1:0][2:0] s_rate;
        logic s_req, s_err;
        int nz;
        @(negedge clk);
        mode_in[0] = m1; mode_in[1] = m2;
        pcm_in[0] = p1;  pcm_in[1] = p2;
        adp_in[0] = a1;  adp_in[1] = a2;
        frm_pulse = 1'b1;
        h_mode[fidx][0] = m1; h_mode[fidx][1] = m2;
        h_pcm[fidx][0] = p1;  h_pcm[fidx][1] = p2;
        h_adp[fidx][0] = a1;  h_adp[fidx][1] = a2;
        nz = int'(m1 == 2'b00) + int'(m2 == 2'b00);
        zrun = (nz == NCH) ? zrun + 1 : 0;
        @(negedge clk);
        frm_pulse = 1'b0;
        for (int ch = 0; ch < NCH; ch++) begin
            logic [1:0] pm;
            pm = hm(fidx - 1, ch);
            chk({ph, "/", mtag(pm), " adp"}, int'(adp_out[ch]),
                int'(exp_adp(pm, hp(fidx - 2, ch))));
            chk({ph, "/", mtag(pm), " pcm"}, int'(pcm_out[ch]),
                int'(exp_pcm(pm, ha(fidx - 2, ch))));
            chk({ph, "/R1 rate"}, int'(rate_sel[ch]), exp_rate(hm(fidx, ch)));
        end
        chk({ph, "/R8 reset_req"}, int'(reset_req), int'(zrun >= 4));
        chk({ph, "/R9 part_err"}, int'(nz > 0 && nz < NCH), int'(part_rst_err));
        s_pcm = pcm_out; s_adp = adp_out; s_rate = rate_sel;
        s_req = reset_req; s_err = part_rst_err;
        // scramble inputs between pulses: they must have no effect
        mode_in = 4'($urandom); pcm_in = 16'($urandom); adp_in = 8'($urandom);
        repeat (FRAME_LEN - 2) @(negedge clk);
        chk({ph, "/R6 pcm hold"}, int'(pcm_out), int'(s_pcm));
        chk({ph, "/R6 adp hold"}, int'(adp_out), int'(s_adp));
        chk({ph, "/R1 rate hold"}, int'(rate_sel), int'(s_rate));
        chk({ph, "/R8 flags hold"}, int'({reset_req, part_rst_err}), int'({s_req, s_err}));
        fidx++;
    endtask

    task automatic rnd_frame(string ph, logic [1:0] m1, logic [1:0] m2);
        do_frame(ph, m1, m2, 8'($urandom), 8'($urandom), 4'($urandom), 4'($urandom));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; frm_pulse = 1'b0;
        mode_in = '1; pcm_in = 16'hA5C3; adp_in = 8'h9E;
        repeat (3) @(negedge clk);
        // R10: outputs zero during reset
        chk("R10 during reset", int'({pcm_out, adp_out, rate_sel, reset_req, part_rst_err}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 after reset", int'({pcm_out, adp_out, rate_sel, reset_req, part_rst_err}), 0);

        // R2: channels in different modes at once
        do_frame("R2", 2'b11, 2'b01, 8'h3C, 8'hF0, 4'h5, 4'hA);
        do_frame("R2", 2'b11, 2'b01, 8'h81, 8'h7E, 4'hC, 4'h3);
        do_frame("R2", 2'b10, 2'b11, 8'hFF, 8'h12, 4'hF, 4'h1);
        do_frame("R2", 2'b01, 2'b10, 8'h00, 8'h96, 4'h7, 4'hB);

        // R7: rate alternates every frame
        for (int i = 0; i < 6; i++)
            rnd_frame("R7", (i % 2 == 0) ? 2'b11 : 2'b10, (i % 2 == 0) ? 2'b10 : 2'b11);

        // R8: three zero frames then release, no request
        for (int i = 0; i < 3; i++) rnd_frame("R8", 2'b00, 2'b00);
        rnd_frame("R8", 2'b11, 2'b11);
        // R8: long reset, request at fourth pulse, saturates, drops
        for (int i = 0; i < 10; i++) rnd_frame("R8", 2'b00, 2'b00);
        rnd_frame("R8", 2'b01, 2'b00);
        rnd_frame("R8", 2'b11, 2'b11);

        // R9: one-sided reset on each side
        for (int i = 0; i < 3; i++) rnd_frame("R9", 2'b00, 2'b11);
        for (int i = 0; i < 3; i++) rnd_frame("R9", 2'b10, 2'b00);

        // R5: bypass with extreme values
        do_frame("R5", 2'b01, 2'b01, 8'hFF, 8'h0F, 4'hF, 4'h0);
        do_frame("R5", 2'b01, 2'b01, 8'h80, 8'h7F, 4'h8, 4'h1);
        do_frame("R5", 2'b01, 2'b01, 8'h00, 8'hF0, 4'h0, 4'hF);

        // R6: constrained random frames, modes biased toward coding
        for (int i = 0; i < 120; i++) begin
            logic [1:0] r1, r2;
            r1 = ($urandom % 5 == 0) ? 2'($urandom) : 2'b11 - 2'($urandom % 2);
            r2 = ($urandom % 5 == 0) ? 2'($urandom) : 2'b11 - 2'($urandom % 3);
            rnd_frame("R6", r1, r2);
        end
        for (int i = 0; i < 2; i++) rnd_frame("R6", 2'b11, 2'b11);

        finish_run();
    end
endmodule